// File: doc/BRIEF.md
# Partitioned Multi-Bank Memory Crossbar

The crossbar connects four initiators to a memory built from four independent banks, each one 128 bits wide. Two 64-bit initiators (a code port and a data port), a 32-bit bitstream-loading port and an 8-bit maintenance port each present a byte address. The crossbar decodes that address into a bank, a row and a lane within the 128-bit word. It checks the address against the partition window programmed for that port and queues the access on the bank it targets. When the access finishes, the crossbar hands the right slice of the bank word back to the port.

The code, data and bitstream ports each own a window of the address space. The window is set by an inclusive base and limit on configuration inputs. When the windows are laid over different banks, the three ports run in parallel, each at the full rate of its bank. The maintenance port is not window-checked and may reach any bank. Each bank is a fixed-latency unit with its own busy counter. Conflicts on one bank are settled by a fixed priority, and the losing ports stall with their request held.

Top module: `mbank_xbar`

## Requirements
- R1: After reset, every port's done and err outputs are low and every rdata output is zero.
- R2: A byte address is decoded as follows: bits [3:0] give the offset within the 128-bit word, the next ROW_BITS bits give the row, and the top two bits give the bank. Data written through a port at an address is returned by a later read of the same address.
- R3: An access accepted by an idle bank in cycle t raises done for exactly one cycle in cycle t+LAT (LAT = 4 by default). A read's rdata is valid while done is high, and err stays low.
- R4: Each port accesses only its own lane of the 128-bit word. The 64-bit ports use lane addr[3], the 32-bit port uses lane addr[3:2] and the 8-bit port uses lane addr[3:0]. A write changes only its lane, and a read returns only that lane.
- R5: The code, data and bitstream ports accept an address only when base <= addr <= limit for that port, bounds included. An address outside the window gives done together with err in the cycle after the request, and it leaves memory unchanged. The maintenance port is never rejected.
- R6: Accesses from several ports to different idle banks in the same cycle are all accepted together and complete in the same cycle.
- R7: When several ports request the same idle bank, the bank is granted in the order code, data, bitstream, maintenance. Each loser is served LAT cycles after the previous winner was accepted.
- R8: A bank accepts a new access only after its previous access has completed. A request to a busy bank waits, and the bank is accepted again in the cycle after the previous done. Busy banks do not delay requests to other banks.
- R9: A port holds its request until done. A request still presented in the done cycle is treated as a new access and is accepted in the following cycle. Done never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_base | input | AW | Lowest byte address of the code window |
| code_limit | input | AW | Highest byte address of the code window |
| data_base | input | AW | Lowest byte address of the data window |
| data_limit | input | AW | Highest byte address of the data window |
| cfg_base | input | AW | Lowest byte address of the bitstream window |
| cfg_limit | input | AW | Highest byte address of the bitstream window |
| code_req | input | 1 | Code port request, held until done |
| code_we | input | 1 | Code port write (1) or read (0) |
| code_addr | input | AW | Code port byte address |
| code_wdata | input | 64 | Code port write data |
| code_done | output | 1 | Code port completion pulse |
| code_err | output | 1 | Code port window violation, valid with done |
| code_rdata | output | 64 | Code port read data |
| data_req | input | 1 | Data port request |
| data_we | input | 1 | Data port write |
| data_addr | input | AW | Data port byte address |
| data_wdata | input | 64 | Data port write data |
| data_done | output | 1 | Data port completion pulse |
| data_err | output | 1 | Data port window violation |
| data_rdata | output | 64 | Data port read data |
| cfg_req | input | 1 | Bitstream port request |
| cfg_we | input | 1 | Bitstream port write |
| cfg_addr | input | AW | Bitstream port byte address |
| cfg_wdata | input | 32 | Bitstream port write data |
| cfg_done | output | 1 | Bitstream port completion pulse |
| cfg_err | output | 1 | Bitstream port window violation |
| cfg_rdata | output | 32 | Bitstream port read data |
| aux_req | input | 1 | Maintenance port request |
| aux_we | input | 1 | Maintenance port write |
| aux_addr | input | AW | Maintenance port byte address |
| aux_wdata | input | 8 | Maintenance port write data |
| aux_done | output | 1 | Maintenance port completion pulse |
| aux_err | output | 1 | Maintenance port error (always low) |
| aux_rdata | output | 8 | Maintenance port read data |

AW = ROW_BITS + 6 (12 by default).

## Verification
Inputs are driven at a falling edge, and each check counts falling edges from that point. A window violation must show done and err one falling edge later. An uncontended access must show done four falling edges later. A port stalled behind k earlier winners on the same bank must show done at 4(k+1). A request that arrives two edges into a busy access must show done at edge 8. A request held through its done pulse must show done again at edge 9. For every port the bench records the edge at which done is first seen and compares it with these figures. It also checks that done is low on the edge after each pulse. Read data and err are compared in the same sample as done, against values the bench builds from the lane rule.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NUM_INIT   = 4;
  localparam int NUM_BANK   = 4;
  localparam int WORD_W     = 128;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int OFS_BITS   = $clog2(WORD_BYTES);
  localparam int BANK_BITS  = $clog2(NUM_BANK);
  localparam int INIT_BITS  = $clog2(NUM_INIT);

  typedef logic [INIT_BITS-1:0] init_id_t;

  // byte enables of one lane of pbytes bytes
  function automatic logic [WORD_BYTES-1:0] lane_be(input logic [OFS_BITS-1:0] lane,
                                                    input int unsigned pbytes);
    return WORD_BYTES'(((32'd1 << pbytes) - 32'd1) << (32'(lane) * pbytes));
  endfunction

  // widen byte enables to a bit mask
  function automatic logic [WORD_W-1:0] be_to_mask(input logic [WORD_BYTES-1:0] be);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < WORD_BYTES; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  // lane slice of the bank word, lowest bits of the result
  function automatic logic [WORD_W-1:0] lane_extract(input logic [WORD_W-1:0] w,
                                                     input logic [OFS_BITS-1:0] lane,
                                                     input int unsigned pbits);
    return w >> (32'(lane) * pbits);
  endfunction

  // fixed priority: lowest index wins
  function automatic logic [NUM_INIT-1:0] first_one(input logic [NUM_INIT-1:0] r);
    logic [NUM_INIT-1:0] g;
    logic found;
    g = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_INIT; i++) begin
      if (r[i] && !found) begin
        g[i] = 1'b1;
        found = 1'b1;
      end
    end
    return g;
  endfunction
endpackage

// File: rtl/mbx_bank.sv
module mbx_bank
  import mbx_pkg::*;
#(
  parameter int ROW_BITS = 6,
  parameter int LAT      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  input  init_id_t              owner_in,
  input  logic                  we_in,
  input  logic [ROW_BITS-1:0]   row_in,
  input  logic [WORD_W-1:0]     wdata_in,
  input  logic [WORD_BYTES-1:0] be_in,
  output logic                  busy,
  output logic                  fin,
  output init_id_t              owner,
  output logic [WORD_W-1:0]     rword
);
  localparam int ROWS = 1 << ROW_BITS;
  localparam int CW   = (LAT > 2) ? $clog2(LAT - 1) : 1;

  logic                  busy_q;
  logic [CW-1:0]         cnt_q;
  logic                  we_q;
  logic [ROW_BITS-1:0]   row_q;
  logic [WORD_W-1:0]     wd_q;
  logic [WORD_BYTES-1:0] be_q;
  init_id_t              owner_q;
  logic [WORD_W-1:0]     mem [ROWS];

  assign fin   = busy_q && (cnt_q == '0);
  assign busy  = busy_q;
  assign owner = owner_q;
  assign rword = mem[row_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      row_q   <= '0;
      wd_q    <= '0;
      be_q    <= '0;
      owner_q <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      cnt_q   <= CW'(LAT - 2);
      we_q    <= we_in;
      row_q   <= row_in;
      wd_q    <= wdata_in;
      be_q    <= be_in;
      owner_q <= owner_in;
    end else if (fin) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fin && we_q)
      mem[row_q] <= (mem[row_q] & ~be_to_mask(be_q)) | (wd_q & be_to_mask(be_q));
  end

  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy_q); // R8
  AST_FIN_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy_q || $past(accept)); // R8
endmodule

// File: rtl/mbx_arb.sv
module mbx_arb
  import mbx_pkg::*;
(
  input  logic [NUM_INIT-1:0] cand,
  input  logic                idle,
  output logic [NUM_INIT-1:0] gnt
);
  always_comb begin
    gnt = idle ? first_one(cand) : '0;
  end
endmodule

// File: rtl/mbx_port.sv
module mbx_port
  import mbx_pkg::*;
#(
  parameter int PW       = 64,
  parameter int ROW_BITS = 6,
  parameter int AW       = ROW_BITS + OFS_BITS + BANK_BITS,
  parameter bit HAS_PART = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  we,
  input  logic [AW-1:0]         addr,
  input  logic [PW-1:0]         wdata,
  input  logic [AW-1:0]         base,
  input  logic [AW-1:0]         limit,
  input  logic                  grant,
  input  logic                  fin_hit,
  input  logic [WORD_W-1:0]     rword,
  output logic                  elig,
  output logic [BANK_BITS-1:0]  bank,
  output logic [ROW_BITS-1:0]   row,
  output logic                  we_o,
  output logic [WORD_W-1:0]     wdata_o,
  output logic [WORD_BYTES-1:0] be_o,
  output logic                  done,
  output logic                  err,
  output logic [PW-1:0]         rdata
);
  localparam int PB    = PW / 8;
  localparam int LANES = WORD_BYTES / PB;
  localparam int SH    = $clog2(PB);
  localparam int LW    = OFS_BITS - SH;

  logic          pend_q, done_q, err_q;
  logic [PW-1:0] rdata_q;
  logic [LW-1:0] lane, lane_q;
  logic          in_part, live, bad;

  assign in_part = HAS_PART ? ((addr >= base) && (addr <= limit)) : 1'b1;
  assign live    = req && !pend_q && !done_q;
  assign elig    = live && in_part;
  assign bad     = live && !in_part;

  assign bank    = addr[AW-1 -: BANK_BITS];
  assign row     = addr[OFS_BITS +: ROW_BITS];
  assign lane    = addr[OFS_BITS-1:SH];
  assign we_o    = we;
  assign wdata_o = {LANES{wdata}};
  assign be_o    = lane_be(OFS_BITS'(lane), PB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
      lane_q  <= '0;
    end else begin
      done_q <= fin_hit || bad;
      err_q  <= bad;
      if (grant) begin
        pend_q <= 1'b1;
        lane_q <= lane;
      end else if (fin_hit) begin
        pend_q <= 1'b0;
      end
      if (fin_hit) rdata_q <= PW'(lane_extract(rword, OFS_BITS'(lane_q), PW));
    end
  end

  assign done  = done_q;
  assign err   = err_q;
  assign rdata = rdata_q;

  AST_BAD_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    bad |-> !grant); // R5
  AST_GRANT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !pend_q); // R9
  AST_FIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    fin_hit |-> pend_q); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
endmodule

// File: rtl/mbank_xbar.sv
module mbank_xbar
  import mbx_pkg::*;
#(
  parameter int ROW_BITS = 6,
  parameter int LAT      = 4,
  parameter int AW       = ROW_BITS + OFS_BITS + BANK_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] code_base,
  input  logic [AW-1:0] code_limit,
  input  logic [AW-1:0] data_base,
  input  logic [AW-1:0] data_limit,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_limit,
  input  logic          code_req,
  input  logic          code_we,
  input  logic [AW-1:0] code_addr,
  input  logic [63:0]   code_wdata,
  output logic          code_done,
  output logic          code_err,
  output logic [63:0]   code_rdata,
  input  logic          data_req,
  input  logic          data_we,
  input  logic [AW-1:0] data_addr,
  input  logic [63:0]   data_wdata,
  output logic          data_done,
  output logic          data_err,
  output logic [63:0]   data_rdata,
  input  logic          cfg_req,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic          cfg_done,
  output logic          cfg_err,
  output logic [31:0]   cfg_rdata,
  input  logic          aux_req,
  input  logic          aux_we,
  input  logic [AW-1:0] aux_addr,
  input  logic [7:0]    aux_wdata,
  output logic          aux_done,
  output logic          aux_err,
  output logic [7:0]    aux_rdata
);
  logic [NUM_INIT-1:0]   elig, grant, fin_hit, pwe;
  logic [BANK_BITS-1:0]  pbank [NUM_INIT];
  logic [ROW_BITS-1:0]   prow  [NUM_INIT];
  logic [WORD_W-1:0]     pwd   [NUM_INIT];
  logic [WORD_BYTES-1:0] pbe   [NUM_INIT];
  logic [WORD_W-1:0]     pword [NUM_INIT];

  logic [NUM_INIT-1:0]   cand  [NUM_BANK];
  logic [NUM_INIT-1:0]   gnt   [NUM_BANK];
  logic [NUM_BANK-1:0]   accept, bbusy, bfin;
  init_id_t              own_in [NUM_BANK];
  init_id_t              own    [NUM_BANK];
  logic                  bwe    [NUM_BANK];
  logic [ROW_BITS-1:0]   brow   [NUM_BANK];
  logic [WORD_W-1:0]     bwd    [NUM_BANK];
  logic [WORD_BYTES-1:0] bbe    [NUM_BANK];
  logic [WORD_W-1:0]     bword  [NUM_BANK];

  mbx_port #(.PW(64), .ROW_BITS(ROW_BITS), .AW(AW), .HAS_PART(1'b1)) u_code (
    .clk, .rst_n, .req(code_req), .we(code_we), .addr(code_addr), .wdata(code_wdata),
    .base(code_base), .limit(code_limit), .grant(grant[0]), .fin_hit(fin_hit[0]),
    .rword(pword[0]), .elig(elig[0]), .bank(pbank[0]), .row(prow[0]), .we_o(pwe[0]),
    .wdata_o(pwd[0]), .be_o(pbe[0]), .done(code_done), .err(code_err), .rdata(code_rdata));

  mbx_port #(.PW(64), .ROW_BITS(ROW_BITS), .AW(AW), .HAS_PART(1'b1)) u_data (
    .clk, .rst_n, .req(data_req), .we(data_we), .addr(data_addr), .wdata(data_wdata),
    .base(data_base), .limit(data_limit), .grant(grant[1]), .fin_hit(fin_hit[1]),
    .rword(pword[1]), .elig(elig[1]), .bank(pbank[1]), .row(prow[1]), .we_o(pwe[1]),
    .wdata_o(pwd[1]), .be_o(pbe[1]), .done(data_done), .err(data_err), .rdata(data_rdata));

  mbx_port #(.PW(32), .ROW_BITS(ROW_BITS), .AW(AW), .HAS_PART(1'b1)) u_cfg (
    .clk, .rst_n, .req(cfg_req), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .base(cfg_base), .limit(cfg_limit), .grant(grant[2]), .fin_hit(fin_hit[2]),
    .rword(pword[2]), .elig(elig[2]), .bank(pbank[2]), .row(prow[2]), .we_o(pwe[2]),
    .wdata_o(pwd[2]), .be_o(pbe[2]), .done(cfg_done), .err(cfg_err), .rdata(cfg_rdata));

  mbx_port #(.PW(8), .ROW_BITS(ROW_BITS), .AW(AW), .HAS_PART(1'b0)) u_aux (
    .clk, .rst_n, .req(aux_req), .we(aux_we), .addr(aux_addr), .wdata(aux_wdata),
    .base('0), .limit('1), .grant(grant[3]), .fin_hit(fin_hit[3]),
    .rword(pword[3]), .elig(elig[3]), .bank(pbank[3]), .row(prow[3]), .we_o(pwe[3]),
    .wdata_o(pwd[3]), .be_o(pbe[3]), .done(aux_done), .err(aux_err), .rdata(aux_rdata));

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    for (genvar i = 0; i < NUM_INIT; i++) begin : g_cand
      assign cand[b][i] = elig[i] && (pbank[i] == BANK_BITS'(b));
    end

    mbx_arb u_arb (.cand(cand[b]), .idle(!bbusy[b]), .gnt(gnt[b]));

    assign accept[b] = |gnt[b];

    always_comb begin
      own_in[b] = '0;
      bwe[b]    = 1'b0;
      brow[b]   = '0;
      bwd[b]    = '0;
      bbe[b]    = '0;
      for (int i = 0; i < NUM_INIT; i++) begin
        if (gnt[b][i]) begin
          own_in[b] = INIT_BITS'(i);
          bwe[b]    = pwe[i];
          brow[b]   = prow[i];
          bwd[b]    = pwd[i];
          bbe[b]    = pbe[i];
        end
      end
    end

    mbx_bank #(.ROW_BITS(ROW_BITS), .LAT(LAT)) u_bank (
      .clk, .rst_n, .accept(accept[b]), .owner_in(own_in[b]), .we_in(bwe[b]),
      .row_in(brow[b]), .wdata_in(bwd[b]), .be_in(bbe[b]), .busy(bbusy[b]),
      .fin(bfin[b]), .owner(own[b]), .rword(bword[b]));

    AST_CODE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (elig[0] && pbank[0] == BANK_BITS'(b) && !bbusy[b]) |-> gnt[b][0]); // R7
    AST_IDLE_SERVES: assert property (@(posedge clk) disable iff (!rst_n)
      ((|cand[b]) && !bbusy[b]) |-> accept[b]); // R6
  end

  always_comb begin
    for (int i = 0; i < NUM_INIT; i++) begin
      grant[i]   = 1'b0;
      fin_hit[i] = 1'b0;
      pword[i]   = '0;
      for (int b = 0; b < NUM_BANK; b++) begin
        if (gnt[b][i]) grant[i] = 1'b1;
        if (bfin[b] && own[b] == INIT_BITS'(i)) begin
          fin_hit[i] = 1'b1;
          pword[i]   = bword[b];
        end
      end
    end
  end

  AST_ONE_FIN_EACH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bfin & {bbusy}) <= NUM_BANK && $onehot0(fin_hit & grant)); // R9
endmodule

// File: tb/mbank_xbar_bench.sv
module mbank_xbar_bench;
  localparam int CLK_P = 10;
  localparam int RB    = 6;
  localparam int AW    = RB + 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [AW-1:0] cb, cl, db, dl, fb, fl;
  logic c_req = 0, c_we = 0, d_req = 0, d_we = 0, f_req = 0, f_we = 0, a_req = 0, a_we = 0;
  logic [AW-1:0] c_addr = '0, d_addr = '0, f_addr = '0, a_addr = '0;
  logic [63:0] c_wd = '0, d_wd = '0;
  logic [31:0] f_wd = '0;
  logic [7:0]  a_wd = '0;
  wire c_done, c_err, d_done, d_err, f_done, f_err, a_done, a_err;
  wire [63:0] c_rd, d_rd;
  wire [31:0] f_rd;
  wire [7:0]  a_rd;

  mbank_xbar #(.ROW_BITS(RB), .LAT(4)) u_mbank_xbar (
    .clk, .rst_n, .code_base(cb), .code_limit(cl), .data_base(db), .data_limit(dl),
    .cfg_base(fb), .cfg_limit(fl),
    .code_req(c_req), .code_we(c_we), .code_addr(c_addr), .code_wdata(c_wd),
    .code_done(c_done), .code_err(c_err), .code_rdata(c_rd),
    .data_req(d_req), .data_we(d_we), .data_addr(d_addr), .data_wdata(d_wd),
    .data_done(d_done), .data_err(d_err), .data_rdata(d_rd),
    .cfg_req(f_req), .cfg_we(f_we), .cfg_addr(f_addr), .cfg_wdata(f_wd),
    .cfg_done(f_done), .cfg_err(f_err), .cfg_rdata(f_rd),
    .aux_req(a_req), .aux_we(a_we), .aux_addr(a_addr), .aux_wdata(a_wd),
    .aux_done(a_done), .aux_err(a_err), .aux_rdata(a_rd));

  int n_cmp = 0, n_bad = 0;
  int st[4], start_at[4], rec_k[4], extra[4];
  logic rec_err[4];
  logic [63:0] rec_rd[4];
  logic p_we[4];
  logic [AW-1:0] p_a[4];
  logic [63:0] p_wd[4];

  localparam logic [63:0] VA = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] VB = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] VD = 64'h1122_3344_5566_7788;
  localparam logic [31:0] VC = 32'hCAFE_F00D;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input int p, input logic on);
    case (p)
      0: begin c_req = on; c_we = p_we[0]; c_addr = p_a[0]; c_wd = p_wd[0]; end
      1: begin d_req = on; d_we = p_we[1]; d_addr = p_a[1]; d_wd = p_wd[1]; end
      2: begin f_req = on; f_we = p_we[2]; f_addr = p_a[2]; f_wd = p_wd[2][31:0]; end
      default: begin a_req = on; a_we = p_we[3]; a_addr = p_a[3]; a_wd = p_wd[3][7:0]; end
    endcase
  endtask

  function automatic logic dn(input int p);
    case (p)
      0: return c_done;
      1: return d_done;
      2: return f_done;
      default: return a_done;
    endcase
  endfunction

  function automatic logic er(input int p);
    case (p)
      0: return c_err;
      1: return d_err;
      2: return f_err;
      default: return a_err;
    endcase
  endfunction

  function automatic logic [63:0] rd(input int p);
    case (p)
      0: return c_rd;
      1: return d_rd;
      2: return {32'd0, f_rd};
      default: return {56'd0, a_rd};
    endcase
  endfunction

  task automatic clr();
    for (int p = 0; p < 4; p++) begin
      st[p] = 0; extra[p] = 0; rec_k[p] = -1; rec_err[p] = 1'bx; rec_rd[p] = 'x;
    end
  endtask

  task automatic setp(input int p, input logic w, input logic [AW-1:0] a,
                      input logic [63:0] v, input int s);
    p_we[p] = w; p_a[p] = a; p_wd[p] = v; start_at[p] = s; st[p] = 1;
  endtask

  // k counts falling edges from the one where stimulus starts
  task automatic run();
    int k;
    bit more;
    k = 0;
    for (int p = 0; p < 4; p++) if (st[p] == 1 && start_at[p] == 0) begin drive(p, 1); st[p] = 2; end
    more = 1'b1;
    while (more && k < 60) begin
      @(negedge clk);
      k++;
      for (int p = 0; p < 4; p++) begin
        if (st[p] == 2 && dn(p)) begin
          rec_k[p] = k; rec_rd[p] = rd(p); rec_err[p] = er(p);
          drive(p, 0); st[p] = 3;
        end else if (st[p] == 3 && dn(p)) extra[p]++;
      end
      for (int p = 0; p < 4; p++) if (st[p] == 1 && start_at[p] == k) begin drive(p, 1); st[p] = 2; end
      more = 1'b0;
      for (int p = 0; p < 4; p++) if (st[p] == 1 || st[p] == 2) more = 1'b1;
    end
    @(negedge clk);
    for (int p = 0; p < 4; p++) if (st[p] == 3 && dn(p)) extra[p]++;
  endtask

  task automatic single(input int p, input logic w, input logic [AW-1:0] a, input logic [63:0] v);
    clr(); setp(p, w, a, v, 0); run();
  endtask

  task automatic t_reset();
    chk("R1 code done", {62'd0, c_done, c_err}, 64'd0);
    chk("R1 data done", {62'd0, d_done, d_err}, 64'd0);
    chk("R1 cfg done",  {62'd0, f_done, f_err}, 64'd0);
    chk("R1 aux done",  {62'd0, a_done, a_err}, 64'd0);
    chk("R1 rdata", c_rd | d_rd | {32'd0, f_rd} | {56'd0, a_rd}, 64'd0);
  endtask

  task automatic t_write_read();
    single(0, 1, 12'h010, VA);
    chk("R3 write latency", 64'(rec_k[0]), 64'd4);
    chk("R3 write err", {63'd0, rec_err[0]}, 64'd0);
    single(0, 1, 12'h018, VB);
    single(0, 0, 12'h010, 64'd0);
    chk("R3 read latency", 64'(rec_k[0]), 64'd4);
    chk("R2 readback lane0", rec_rd[0], VA);
    chk("R3 single done pulse", 64'(extra[0]), 64'd0);
    single(0, 0, 12'h018, 64'd0);
    chk("R4 readback lane1", rec_rd[0], VB);
  endtask

  task automatic t_parallel();
    clr();
    setp(0, 0, 12'h010, 64'd0, 0);
    setp(1, 1, 12'h420, VD, 0);
    setp(2, 1, 12'h824, {32'd0, VC}, 0);
    run();
    chk("R6 code parallel", 64'(rec_k[0]), 64'd4);
    chk("R6 data parallel", 64'(rec_k[1]), 64'd4);
    chk("R6 cfg parallel",  64'(rec_k[2]), 64'd4);
    chk("R6 code data", rec_rd[0], VA);
    single(1, 0, 12'h420, 64'd0);
    chk("R2 data readback", rec_rd[1], VD);
  endtask

  task automatic t_narrow();
    single(3, 0, 12'h826, 64'd0);
    chk("R4 aux byte of cfg word", rec_rd[3], {56'd0, VC[23:16]});
    chk("R5 aux never err", {63'd0, rec_err[3]}, 64'd0);
    single(3, 1, 12'h827, 64'h5A);
    single(2, 0, 12'h824, 64'd0);
    chk("R4 cfg sees aux byte", rec_rd[2], {32'd0, 8'h5A, VC[23:0]});
  endtask

  task automatic t_partition();
    single(0, 0, 12'h400, 64'd0);
    chk("R5 code above limit err", {63'd0, rec_err[0]}, 64'd1);
    chk("R5 err latency", 64'(rec_k[0]), 64'd1);
    single(2, 1, 12'h010, 64'hFFFF_FFFF);
    chk("R5 cfg outside err", {63'd0, rec_err[2]}, 64'd1);
    single(0, 0, 12'h010, 64'd0);
    chk("R5 memory untouched", rec_rd[0], VA);
    single(0, 1, 12'h3F8, VB);
    single(0, 0, 12'h3F8, 64'd0);
    chk("R5 limit inclusive", {rec_rd[0][62:0], rec_err[0]}, {VB[62:0], 1'b0});
    single(1, 0, 12'h3F8, 64'd0);
    chk("R5 data below base err", {63'd0, rec_err[1]}, 64'd1);
    single(1, 0, 12'h400, 64'd0);
    chk("R5 base inclusive", {63'd0, rec_err[1]}, 64'd0);
  endtask

  task automatic t_priority();
    cb = '0; cl = '1; db = '0; dl = '1; fb = '0; fl = '1;
    clr();
    setp(3, 0, 12'hC20, 64'd0, 0);
    setp(2, 0, 12'hC10, 64'd0, 0);
    setp(1, 0, 12'hC08, 64'd0, 0);
    setp(0, 0, 12'hC00, 64'd0, 0);
    run();
    chk("R7 code first",  64'(rec_k[0]), 64'd4);
    chk("R7 data second", 64'(rec_k[1]), 64'd8);
    chk("R7 cfg third",   64'(rec_k[2]), 64'd12);
    chk("R7 aux last",    64'(rec_k[3]), 64'd16);
  endtask

  task automatic t_busy();
    clr();
    setp(0, 1, 12'hC00, VD, 0);
    setp(1, 0, 12'hC40, 64'd0, 2);
    setp(2, 0, 12'h824, 64'd0, 0);
    run();
    chk("R8 code on bank3", 64'(rec_k[0]), 64'd4);
    chk("R8 data waits busy bank", 64'(rec_k[1]), 64'd8);
    chk("R8 other bank unaffected", 64'(rec_k[2]), 64'd4);
  endtask

  task automatic t_pulse();
    logic [63:0] got;
    cb = 12'h000; cl = 12'h3FF;
    p_we[0] = 0; p_a[0] = 12'h010; p_wd[0] = '0;
    drive(0, 1);
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      if (k == 4) begin
        chk("R9 first done", {63'd0, c_done}, 64'd1);
        chk("R9 first data", c_rd, VA);
        p_a[0] = 12'h018;
        drive(0, 1);
      end
      if (k == 5) chk("R9 done one cycle", {63'd0, c_done}, 64'd0);
      if (k == 8) chk("R9 not early", {63'd0, c_done}, 64'd0);
      if (k == 9) begin
        got = c_rd;
        chk("R9 second done", {63'd0, c_done}, 64'd1);
        chk("R9 second data", got, VB);
        drive(0, 0);
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL R3 watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cb = 12'h000; cl = 12'h3FF;
    db = 12'h400; dl = 12'h7FF;
    fb = 12'h800; fl = 12'hBFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_parallel();
    t_narrow();
    t_partition();
    cb = 12'h000; cl = 12'h3FF; db = 12'h400; dl = 12'h7FF; fb = 12'h800; fl = 12'hBFF;
    t_priority();
    t_busy();
    t_pulse();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule